// File: doc/BRIEF.md
# Dual-Counter Autoreload PWM Timer

This block generates four pulse-width modulated outputs from 12-bit up-counters. A counter advances on each cycle where the counter clock enable is high. After it reaches 4095 it overflows and restarts from a programmable reload value, so the PWM period is 4096 minus the reload value, in enabled cycles. Each output goes high at overflow and goes low once the counter reaches that channel's active duty value. A channel whose active duty value does not exceed the reload value holds a constant level.

Software writes duty values, polarity bits and the reload values through a small register write port. Duty and polarity are double-buffered. Writes land in preload storage and move to the active copies only at an overflow of the governing counter, and only while that counter's transfer flag is armed. A small state machine per counter holds the transfer flag. It has two states: ARM_PENDING, entered at reset, and ARM_IDLE. ARM_IDLE goes to ARM_PENDING when software writes the arm bit. ARM_PENDING goes to ARM_IDLE at an overflow that performs the transfer, unless the arm bit is written again in that same cycle.

A mode bit switches the upper two channels over to a second counter that has its own reload value and its own transfer flag, so those two channels can run at a separate frequency.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset both counters are 0. Counter 1 advances by one on each cycle with `cnt_en` high and holds when `cnt_en` is low. In an enabled cycle at 4095 it loads its reload value (address 0, bits [11:0]), so the period is 4096 − reload enabled cycles.
- R2: A channel's raw level is high while its counter is below the channel's active duty value and low from the cycle the counter equals that value. It therefore rises at overflow. All outputs are low during and right after reset, because the active duty values reset to 0.
- R3: Duty writes (channel k at address 4+k, bits [11:0]) go to preload storage and have no effect on any output until an overflow with an armed transfer flag. At that overflow the preload value becomes active.
- R4: Each counter's transfer flag is armed at reset. Writing address 3 with bit 0 set arms flag 1, and with bit 1 set arms flag 2. A flag clears itself at the overflow that performs a transfer, unless it is re-armed in that same cycle. An overflow with the flag clear keeps the old active duty and polarity.
- R5: Polarity bits (address 2, bits [8:5], one per channel 0..3) are preloaded. They invert a channel's level only after a transferring overflow of its counter.
- R6: Output-enable bits (address 2, bits [4:1], one per channel 0..3) gate the pins. A disabled pin reads 0 from the cycle after the write.
- R7: Address 2 bit 0 selects dual mode. When it is clear, all channels use counter 1 and flag 1, and counter 2 is held at 0. When it is set, channels 2 and 3 use counter 2, which reloads from address 1 bits [11:0], and flag 2.
- R8: An active duty value at or below the reload value gives a constant low level (0%). With polarity set it gives a constant high level (100%).
- R9: All writes take effect at the clock edge where `wr_en` is high. An overflow in that same cycle uses the values stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 12 | Register write data |
| pwm_o | output | 4 | PWM outputs, channel 0 in bit 0 |

## Verification
A wrong counter value or a wrong reload value moves the edges of every channel driven by that counter, so the error shows at the pins within one PWM period. A transfer flag stuck in the wrong state shows at the next overflow, either as a duty or polarity change that should not happen or as one that fails to happen. A corrupted active duty or polarity copy shows on the affected pin in the first cycle where the counter crosses it. The bench keeps its own cycle model of counters, flags and active copies and compares all four pins on every clock, so each of these errors is reported in the first cycle it reaches a port.

// File: rtl/pwm_dual_timer_pkg.sv
package pwm_dual_timer_pkg;
    typedef enum logic {
        ARM_IDLE    = 1'b0,
        ARM_PENDING = 1'b1
    } arm_state_t;

    localparam int ADDR_W      = 3;
    localparam int A_RELOAD1   = 0;
    localparam int A_RELOAD2   = 1;
    localparam int A_CTRL      = 2;
    localparam int A_ARM       = 3;
    localparam int A_DUTY_BASE = 4;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_dual_timer_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             hold,
    input  logic [CNT_W-1:0] reload,
    input  logic             arm_set,
    output logic [CNT_W-1:0] cnt,
    output logic             xfer
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    arm_state_t state, state_nxt;
    logic       ovf;

    assign ovf  = tick && !hold && (cnt == CNT_MAX);
    assign xfer = ovf && (state == ARM_PENDING);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (hold)
            cnt <= '0;
        else if (tick)
            cnt <= ovf ? reload : cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ARM_PENDING;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ARM_IDLE:    if (arm_set) state_nxt = ARM_PENDING;
            ARM_PENDING: if (ovf && !arm_set) state_nxt = ARM_IDLE;
            default:     state_nxt = ARM_PENDING;
        endcase
    end

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1); // R1
    AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && cnt == CNT_MAX) |=> cnt == $past(reload)); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hold) |=> $stable(cnt)); // R1
    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
        hold |=> cnt == '0); // R7
    AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (xfer && !arm_set) |=> state == ARM_IDLE); // R4
    AST_ARM_SET: assert property (@(posedge clk) disable iff (rst)
        arm_set |=> state == ARM_PENDING); // R4
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_alt,
    input  logic [CNT_W-1:0] cnt_main,
    input  logic [CNT_W-1:0] cnt_alt,
    input  logic             xfer_main,
    input  logic             xfer_alt,
    input  logic [CNT_W-1:0] duty_pre,
    input  logic             pol_pre,
    input  logic             oe,
    output logic             pwm
);
    logic [CNT_W-1:0] duty_act;
    logic             pol_act;
    logic             load;
    logic [CNT_W-1:0] cnt_sel;
    logic             raw;

    assign load    = use_alt ? xfer_alt : xfer_main;
    assign cnt_sel = use_alt ? cnt_alt : cnt_main;
    assign raw     = cnt_sel < duty_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_act <= '0;
            pol_act  <= 1'b0;
        end else if (load) begin
            duty_act <= duty_pre;
            pol_act  <= pol_pre;
        end
    end

    always_comb begin
        pwm = oe && (raw ^ pol_act);
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(duty_act) && $stable(pol_act))); // R4
    AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (duty_act == $past(duty_pre) && pol_act == $past(pol_pre))); // R3
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
    import pwm_dual_timer_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int NCH   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NCH-1:0]    pwm_o
);
    localparam int OE_LO  = 1;
    localparam int POL_LO = OE_LO + NCH;

    logic [CNT_W-1:0] reload1, reload2;
    logic             dual;
    logic [NCH-1:0]   oe_r, pol_pre;
    logic [CNT_W-1:0] duty_pre [NCH];
    logic             arm1, arm2;
    logic [CNT_W-1:0] cnt1, cnt2;
    logic             xfer1, xfer2;

    assign arm1 = wr_en && (wr_addr == ADDR_W'(A_ARM)) && wr_data[0];
    assign arm2 = wr_en && (wr_addr == ADDR_W'(A_ARM)) && wr_data[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload1 <= '0;
            reload2 <= '0;
            dual    <= 1'b0;
            oe_r    <= '0;
            pol_pre <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_RELOAD1)) reload1 <= wr_data;
            if (wr_addr == ADDR_W'(A_RELOAD2)) reload2 <= wr_data;
            if (wr_addr == ADDR_W'(A_CTRL)) begin
                dual    <= wr_data[0];
                oe_r    <= wr_data[OE_LO +: NCH];
                pol_pre <= wr_data[POL_LO +: NCH];
            end
        end
    end

    pwm_counter #(.CNT_W(CNT_W)) u_cnt_main (
        .clk(clk), .rst(rst), .tick(cnt_en), .hold(1'b0),
        .reload(reload1), .arm_set(arm1), .cnt(cnt1), .xfer(xfer1)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt_alt (
        .clk(clk), .rst(rst), .tick(cnt_en), .hold(!dual),
        .reload(reload2), .arm_set(arm2), .cnt(cnt2), .xfer(xfer2)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam bit ALT_CAPABLE = (i >= NCH - 2);

        always_ff @(posedge clk) begin
            if (rst)
                duty_pre[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(A_DUTY_BASE + i))
                duty_pre[i] <= wr_data;
        end

        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst),
            .use_alt(ALT_CAPABLE && dual),
            .cnt_main(cnt1), .cnt_alt(cnt2),
            .xfer_main(xfer1), .xfer_alt(xfer2),
            .duty_pre(duty_pre[i]), .pol_pre(pol_pre[i]), .oe(oe_r[i]),
            .pwm(pwm_o[i])
        );
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> pwm_o == '0); // R2
endmodule

// File: tb/pwm_dual_timer_bench.sv
module pwm_dual_timer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [3:0]  pwm_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string cur_req = "R2";

    int m_c1, m_c2, m_rl1, m_rl2;
    int m_dpre [4];
    int m_dact [4];
    bit m_ppre [4];
    bit m_pact [4];
    bit m_oe   [4];
    bit m_dual, m_arm1, m_arm2;

    always #5 clk = ~clk;

    pwm_dual_timer u_pwm_dual_timer (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_c1 = 0; m_c2 = 0; m_rl1 = 0; m_rl2 = 0;
            m_dual = 0; m_arm1 = 1; m_arm2 = 1;
            for (int k = 0; k < 4; k++) begin
                m_dpre[k] = 0; m_dact[k] = 0;
                m_ppre[k] = 0; m_pact[k] = 0; m_oe[k] = 0;
            end
        end else begin
            bit o1, o2;
            o1 = cnt_en && m_c1 == 4095;
            o2 = cnt_en && m_dual && m_c2 == 4095;
            for (int k = 0; k < 4; k++) begin
                bit alt;
                alt = m_dual && k >= 2;
                if (alt ? (o2 && m_arm2) : (o1 && m_arm1)) begin
                    m_dact[k] = m_dpre[k];
                    m_pact[k] = m_ppre[k];
                end
            end
            if (o1) m_arm1 = 0;
            if (o2) m_arm2 = 0;
            if (cnt_en) m_c1 = o1 ? m_rl1 : m_c1 + 1;
            if (!m_dual) m_c2 = 0;
            else if (cnt_en) m_c2 = o2 ? m_rl2 : m_c2 + 1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_rl1 = wr_data;
                    3'd1: m_rl2 = wr_data;
                    3'd2: begin
                        m_dual = wr_data[0];
                        for (int k = 0; k < 4; k++) begin
                            m_oe[k]   = wr_data[1 + k];
                            m_ppre[k] = wr_data[5 + k];
                        end
                    end
                    3'd3: begin
                        if (wr_data[0]) m_arm1 = 1;
                        if (wr_data[1]) m_arm2 = 1;
                    end
                    default: m_dpre[wr_addr - 4] = wr_data;
                endcase
            end
        end
    end

    function automatic bit exp_pin(int k);
        int c;
        c = (m_dual && k >= 2) ? m_c2 : m_c1;
        return m_oe[k] && ((c < m_dact[k]) ^ m_pact[k]);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        logic [3:0] e;
        cycles++;
        for (int k = 0; k < 4; k++) e[k] = exp_pin(k);
        check(cur_req, pwm_o, e);
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 12'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(string req, int ch, int n, int exp);
        int h;
        h = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_o[ch]) h++;
        end
        check(req, h, exp);
    endtask

    initial begin
        cur_req = "R2";
        run(3);
        check("R2", pwm_o, 0);
        @(negedge clk);
        rst = 1'b0;
        cnt_en = 1'b1;
        // R9: setup writes; R1 first overflow after 4096 cycles from 0
        cur_req = "R9";
        wr(0, 4000);
        for (int k = 0; k < 4; k++) wr(4 + k, 4050);
        wr(2, 12'b0000_1111_0);
        cur_req = "R1";
        run(4200);
        // R1 period of 96 cycles, duty high 50
        count_high("R1", 0, 960, 500);
        // R1 clock enable gating
        for (int j = 0; j < 600; j++) begin
            @(negedge clk);
            cnt_en = (j % 3) != 0;
        end
        cnt_en = 1'b1;
        // R3: duty write without arm has no effect
        cur_req = "R3";
        wr(4, 4020);
        run(300);
        // R4: arm flag 1, transfer then self-clear
        cur_req = "R4";
        wr(3, 1);
        run(200);
        wr(5, 4090);
        run(300);
        // R5: polarity on channel 1, armed
        cur_req = "R5";
        wr(2, 12'b0010_1111_0);
        run(150);
        wr(3, 1);
        run(250);
        // R6: disable channel 2 immediately
        cur_req = "R6";
        wr(2, 12'b0010_1011_0);
        check("R6", pwm_o[2], 0);
        run(200);
        // R7: dual mode, counter 2 period 16
        cur_req = "R7";
        wr(1, 4080);
        wr(6, 4088);
        wr(7, 4085);
        wr(2, 12'b0010_1111_1);
        wr(3, 2);
        run(4300);
        count_high("R7", 2, 160, 80);
        count_high("R7", 3, 160, 50);
        // R8: duty equal to reload gives 0%, then polarity gives 100%
        cur_req = "R8";
        wr(4, 4000);
        wr(3, 1);
        run(200);
        count_high("R8", 0, 192, 0);
        wr(2, 12'b0011_1111_1);
        wr(3, 1);
        run(200);
        count_high("R8", 0, 192, 192);
        // R9: arm written in the overflow cycle keeps flag armed
        cur_req = "R9";
        for (int j = 0; j < 300; j++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 3'd3; wr_data = 12'(j % 2);
        end
        wr_en = 1'b0;
        wr(0, 4050);
        run(300);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule